// File: doc/BRIEF.md
# Adaptive Run-Ahead Token Queue

This block sets how far a prefetching engine may run ahead of the engine that consumes its data. The prefetching side (the producer) pushes one token for each prefetch iteration it finishes. The consuming side pops one token before it starts the matching iteration. Occupancy is the number of tokens held. It can never exceed a run-time limit, so that limit is the allowed run-ahead distance.

The limit adapts to how well prefetching is doing. Over each evaluation period the block counts two kinds of prefetch outcome:

- **Late:** the data arrived after its load had already been issued.
- **Useful:** the data arrived before its load was issued.

On every evaluation strobe the block decides in this order:

1. If the prefetch buffer is full, the limit is held.
2. Otherwise, if twice the late count is greater than the useful count, the limit grows by one.
3. In every other case the limit shrinks by one.

After each decision both counts start again from zero.

Top module: `slip_control_queue`

## Requirements
- R1: After reset the limit equals INIT_LIMIT (default 4), the queue is empty, `pop_valid` is 0 and `push_ready` is 1.
- R2: A push is accepted only when `push_valid` and `push_ready` are both 1. `push_ready` is 1 exactly when occupancy is below the limit, so a queue filled from empty accepts exactly `limit` tokens.
- R3: `pop_valid` is 1 exactly when occupancy is nonzero. `pop_ready` while the queue is empty removes nothing.
- R4: A push and a pop accepted in the same cycle leave occupancy unchanged.
- R5: On an evaluation strobe with `buf_full` = 1, the limit does not change.
- R6: On an evaluation strobe with `buf_full` = 0, if 2×late > useful, the limit rises by one. It saturates at MAX_DEPTH (default 16).
- R7: On an evaluation strobe with `buf_full` = 0 where R6 does not apply, the limit falls by one. It saturates at 1.
- R8: Both outcome counts restart at each evaluation strobe. A late or useful pulse in the strobe cycle itself counts toward the next period only.
- R9: Both outcome counts are 16 bits and saturate at 65535 instead of wrapping. The doubled late count is compared at 17 bits.
- R10: When the limit drops below the current occupancy, no token is lost. `push_ready` stays 0 until occupancy falls below the new limit.
- R11: The limit changes only in the cycle after an evaluation strobe, and it is visible on `depth_limit` from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Producer offers a token |
| push_ready | output | 1 | Queue can take a token |
| pop_ready | input | 1 | Consumer wants a token |
| pop_valid | output | 1 | Queue holds at least one token |
| late_pulse | input | 1 | One prefetch arrived late |
| useful_pulse | input | 1 | One prefetch arrived in time |
| buf_full | input | 1 | Prefetch buffer is full |
| eval_strobe | input | 1 | Make an adaptation decision |
| depth_limit | output | $clog2(MAX_DEPTH+1) | Current occupancy limit |

## Verification
The assertions rely on every input being a clean 0/1 level sampled on the clock. They also rely on the outcome pulses being single-cycle events, each counted once per cycle.

The stimulus drives all inputs shortly after a rising edge and holds them steady until the next one. Pushes are offered only while the bench watches `push_ready`. The table-driven phase feeds a known number of outcome pulses per period and then strobes once.

Long pulse runs reach both count saturation points. Pulses that coincide with a strobe test how periods are split.

// File: rtl/slip_pkg.sv
// Package: shared types for the adaptive run-ahead token queue.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package slip_pkg;

    // Outcome of one adaptation decision.
    typedef enum logic [1:0] {
        ADAPT_HOLD   = 2'd0,
        ADAPT_GROW   = 2'd1,
        ADAPT_SHRINK = 2'd2
    } adapt_e;

    // Outcome counter width fixed by the block definition.
    localparam int unsigned OUTCOME_W = 16;

endpackage

// File: rtl/slip_sat_counter.sv
// Module: saturating event counter with period restart.
// Counts single-cycle pulses and sticks at all-ones.
// A restart loads the pulse of the restart cycle itself, so that event
// belongs to the new period.
// Assumes: inc is a one-cycle event flag; restart is synchronous.
module slip_sat_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             restart,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_q;

    // Count pulses, restart on strobe, stick at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= {{(WIDTH-1){1'b0}}, inc};
        end else if (inc && (count_q != TOP)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R8: a restart leaves at most the restart-cycle pulse.
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count_q <= 1));

    // R9: the counter never wraps from the top value.
    a_r9_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == TOP && !restart) |=> (count_q == TOP));

endmodule

// File: rtl/slip_depth_governor.sv
// Module: adaptive limit register.
// On each evaluation strobe it holds, grows or shrinks the occupancy
// limit by one step, clamped to [1, MAX_DEPTH].
// Assumes: the counts are stable in the strobe cycle; INIT_LIMIT is in range.
module slip_depth_governor
    import slip_pkg::*;
#(
    parameter int unsigned MAX_DEPTH  = 16,
    parameter int unsigned INIT_LIMIT = 4,
    parameter int unsigned CNT_W      = OUTCOME_W,
    parameter int unsigned LIM_W      = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_strobe,
    input  logic             buf_full,
    input  logic [CNT_W-1:0] late_cnt,
    input  logic [CNT_W-1:0] useful_cnt,
    output logic [LIM_W-1:0] limit
);
    localparam logic [LIM_W-1:0] LIM_MAX  = LIM_W'(MAX_DEPTH);
    localparam logic [LIM_W-1:0] LIM_MIN  = LIM_W'(1);
    localparam logic [LIM_W-1:0] LIM_INIT = LIM_W'(INIT_LIMIT);

    logic [CNT_W:0]   late_x2;
    logic [CNT_W:0]   useful_wide;
    adapt_e           choice;
    logic [LIM_W-1:0] limit_q;

    // Widen both counts by one bit so doubling cannot overflow.
    always_comb begin
        late_x2     = {late_cnt, 1'b0};
        useful_wide = {1'b0, useful_cnt};
    end

    // Pick the adaptation step; a full buffer has priority.
    always_comb begin
        if (buf_full) begin
            choice = ADAPT_HOLD;
        end else if (late_x2 > useful_wide) begin
            choice = ADAPT_GROW;
        end else begin
            choice = ADAPT_SHRINK;
        end
    end

    // Apply the step on a strobe, clamped to the legal range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= LIM_INIT;
        end else if (eval_strobe) begin
            case (choice)
                ADAPT_GROW:   if (limit_q != LIM_MAX) limit_q <= limit_q + 1'b1;
                ADAPT_SHRINK: if (limit_q != LIM_MIN) limit_q <= limit_q - 1'b1;
                default:      limit_q <= limit_q;
            endcase
        end
    end

    assign limit = limit_q;

    // R5: a full buffer freezes the limit.
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_strobe && buf_full) |=> $stable(limit_q));

    // R11: no strobe, no change.
    a_r11_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_strobe |=> $stable(limit_q));

    // R6 and R7: the limit stays within [1, MAX_DEPTH].
    a_r6_limit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_q >= LIM_MIN) && (limit_q <= LIM_MAX));

endmodule

// File: rtl/slip_token_count.sv
// Module: token occupancy tracker with ready/valid handshakes.
// Holds only a count because tokens carry no data.
// Pushes are refused while occupancy is at or above the limit.
// Assumes: the limit is at most MAX_DEPTH.
module slip_token_count #(
    parameter int unsigned MAX_DEPTH = 16,
    parameter int unsigned LIM_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic             pop_ready,
    output logic             pop_valid,
    input  logic [LIM_W-1:0] limit
);
    localparam logic [LIM_W-1:0] OCC_MAX = LIM_W'(MAX_DEPTH);

    logic [LIM_W-1:0] occ_q;
    logic             push_fire;
    logic             pop_fire;

    // Handshake outputs follow occupancy and the current limit.
    always_comb begin
        push_ready = (occ_q < limit);
        pop_valid  = (occ_q != '0);
        push_fire  = push_valid && push_ready;
        pop_fire   = pop_ready && pop_valid;
    end

    // Track occupancy; a push and pop together cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (push_fire && !pop_fire) begin
            occ_q <= occ_q + 1'b1;
        end else if (pop_fire && !push_fire) begin
            occ_q <= occ_q - 1'b1;
        end
    end

    // R2: occupancy never exceeds the physical depth.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_MAX);

    // R4: a push and a pop in the same cycle keep occupancy.
    a_r4_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_fire && pop_fire) |=> $stable(occ_q));

    // R3: popping an empty queue leaves it empty.
    a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_valid && !push_valid) |=> (occ_q == '0));

    // R10: a lone pop never leaves more tokens than before.
    a_r10_tokens_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !push_fire) |=> (occ_q == $past(occ_q) - 1'b1));

endmodule

// File: rtl/slip_control_queue.sv
// Module: adaptive run-ahead token queue (top).
// Couples a prefetch producer to a consumer through a token count.
// The count's ceiling is retuned each evaluation period from the
// late/useful prefetch ratio.
// Assumes: single clock; outcome pulses are one-cycle events.
module slip_control_queue
    import slip_pkg::*;
#(
    parameter int unsigned MAX_DEPTH  = 16,
    parameter int unsigned INIT_LIMIT = 4,
    parameter int unsigned LIM_W      = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic             pop_ready,
    output logic             pop_valid,
    input  logic             late_pulse,
    input  logic             useful_pulse,
    input  logic             buf_full,
    input  logic             eval_strobe,
    output logic [LIM_W-1:0] depth_limit
);
    localparam int unsigned N_KIND = 2;

    logic [N_KIND-1:0]    kind_pulse;
    logic [OUTCOME_W-1:0] kind_cnt [N_KIND];
    logic [LIM_W-1:0]     limit_w;

    // Gather the outcome pulses; index 0 is late, index 1 is useful.
    always_comb begin
        kind_pulse = {useful_pulse, late_pulse};
    end

    for (genvar k = 0; k < N_KIND; k++) begin : g_tally
        slip_sat_counter #(.WIDTH(OUTCOME_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (kind_pulse[k]),
            .restart (eval_strobe),
            .count   (kind_cnt[k])
        );
    end

    slip_depth_governor #(
        .MAX_DEPTH  (MAX_DEPTH),
        .INIT_LIMIT (INIT_LIMIT),
        .CNT_W      (OUTCOME_W),
        .LIM_W      (LIM_W)
    ) u_gov (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval_strobe (eval_strobe),
        .buf_full    (buf_full),
        .late_cnt    (kind_cnt[0]),
        .useful_cnt  (kind_cnt[1]),
        .limit       (limit_w)
    );

    slip_token_count #(
        .MAX_DEPTH (MAX_DEPTH),
        .LIM_W     (LIM_W)
    ) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .pop_ready  (pop_ready),
        .pop_valid  (pop_valid),
        .limit      (limit_w)
    );

    assign depth_limit = limit_w;

    // R3: a lone accepted push makes a token visible next cycle.
    a_r3_push_shows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !(pop_ready && pop_valid)) |=> pop_valid);

endmodule

// File: tb/slip_control_queue_test.sv
module slip_control_queue_test;
    localparam int MAX_DEPTH = 16;
    localparam int LIM_W     = $clog2(MAX_DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, pop_ready = 1'b0;
    logic late_pulse = 1'b0, useful_pulse = 1'b0;
    logic buf_full = 1'b0, eval_strobe = 1'b0;
    logic push_ready, pop_valid;
    logic [LIM_W-1:0] depth_limit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slip_control_queue #(.MAX_DEPTH(MAX_DEPTH), .INIT_LIMIT(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_ready(push_ready),
        .pop_ready(pop_ready), .pop_valid(pop_valid),
        .late_pulse(late_pulse), .useful_pulse(useful_pulse),
        .buf_full(buf_full), .eval_strobe(eval_strobe),
        .depth_limit(depth_limit)
    );

    // Table entries: {late count[7:0], useful count[7:0], buf_full, expected limit[4:0]}.
    localparam int NT = 11;
    localparam logic [21:0] TBL [NT] = '{
        {8'd3, 8'd5, 1'b0, 5'd5},   // R6: 6 > 5, grow
        {8'd2, 8'd4, 1'b0, 5'd4},   // R7: 4 == 4, shrink
        {8'd0, 8'd0, 1'b0, 5'd3},   // R7
        {8'd5, 8'd0, 1'b1, 5'd3},   // R5: buffer full, hold
        {8'd1, 8'd1, 1'b0, 5'd4},   // R6: 2 > 1
        {8'd0, 8'd3, 1'b0, 5'd3},   // R7
        {8'd0, 8'd0, 1'b0, 5'd2},   // R7
        {8'd0, 8'd0, 1'b0, 5'd1},   // R7
        {8'd0, 8'd0, 1'b0, 5'd1},   // R7: floor at 1
        {8'd4, 8'd7, 1'b0, 5'd2},   // R6: 8 > 7
        {8'd0, 8'd0, 1'b0, 5'd1}    // R8: previous period's counts are gone
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input int nl, input int nu);
        int n;
        n = (nl > nu) ? nl : nu;
        for (int i = 0; i < n; i++) begin
            late_pulse = (i < nl);
            useful_pulse = (i < nu);
            tick();
        end
        late_pulse = 1'b0;
        useful_pulse = 1'b0;
    endtask

    task automatic evaluate(input logic full);
        buf_full = full;
        eval_strobe = 1'b1;
        tick();
        eval_strobe = 1'b0;
        buf_full = 1'b0;
    endtask

    task automatic fill(output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (!push_ready) break;
            push_valid = 1'b1;
            n++;
            tick();
        end
        push_valid = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (!pop_valid) break;
            pop_ready = 1'b1;
            n++;
            tick();
        end
        pop_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic [21:0] e;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 limit", depth_limit, 4);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R1 push_ready", push_ready, 1);

        // Table-driven adaptation periods (R5 R6 R7 R8 R11)
        for (int t = 0; t < NT; t++) begin
            e = TBL[t];
            send(int'(e[21:14]), int'(e[13:6]));
            chk("R11 limit before strobe", depth_limit, (t == 0) ? 4 : int'(TBL[t-1][4:0]));
            evaluate(e[5]);
            chk($sformatf("R5/R6/R7 table row %0d", t), depth_limit, int'(e[4:0]));
        end

        // R8: a pulse in the strobe cycle counts in the next period
        late_pulse = 1'b1;
        evaluate(1'b0);
        late_pulse = 1'b0;
        chk("R8 strobe-cycle pulse excluded", depth_limit, 1);
        evaluate(1'b0);
        chk("R8 strobe-cycle pulse carried", depth_limit, 2);

        // R9: useful saturates at 65535; 2*32767 = 65534 is not greater -> shrink
        send(32767, 70000);
        evaluate(1'b0);
        chk("R9 useful saturates", depth_limit, 1);
        // R9: 2*40000 = 80000 > 65535 only with a 17-bit compare -> grow
        send(40000, 70000);
        evaluate(1'b0);
        chk("R9 17-bit compare", depth_limit, 2);

        // R6: ceiling at MAX_DEPTH
        for (int i = 0; i < 16; i++) begin
            send(1, 0);
            evaluate(1'b0);
        end
        chk("R6 ceiling", depth_limit, MAX_DEPTH);
        for (int i = 0; i < 12; i++) evaluate(1'b0);
        chk("R7 back to 4", depth_limit, 4);

        // R2: fill from empty accepts exactly limit tokens
        chk("R3 empty not valid", pop_valid, 0);
        fill(n);
        chk("R2 fill count", n, 4);
        chk("R3 valid when holding", pop_valid, 1);

        // R10: shrink below occupancy
        evaluate(1'b0);
        chk("R10 limit shrunk", depth_limit, 3);
        chk("R10 blocked at 4 of 3", push_ready, 0);
        pop_ready = 1'b1; tick(); pop_ready = 1'b0;
        chk("R10 blocked at 3 of 3", push_ready, 0);
        pop_ready = 1'b1; tick(); pop_ready = 1'b0;
        chk("R10 open at 2 of 3", push_ready, 1);

        // R4: push and pop together at occupancy 2
        push_valid = 1'b1; pop_ready = 1'b1; tick();
        push_valid = 1'b0; pop_ready = 1'b0;
        drain(n);
        chk("R4 simultaneous keeps occupancy", n, 2);

        // R3: pop on empty is ignored
        pop_ready = 1'b1;
        repeat (3) tick();
        pop_ready = 1'b0;
        chk("R3 still empty", pop_valid, 0);
        push_valid = 1'b1; tick(); push_valid = 1'b0;
        drain(n);
        chk("R3 one token after empty pops", n, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule